// File: doc/BRIEF.md
# Per-Port Line Reset Request Detector

This block watches the loopback and all-ones control pins of each port of a multi-port line interface. It turns one combination of those pins, which has no use in normal operation, into a reset command for that port's serial-interface registers. The combination is remote loopback high and local loopback high while all-ones transmit is low. It must be held without a break for a minimum time before it counts. The reset does not fire while the request is held. It fires as a single-cycle pulse on the system clock when the request is taken away.

A second path serves host-controlled operation. A control byte written to a selected port carries the same command in three of its bits, and a matching write produces the same single-cycle pulse for that port. Every port has its own synchroniser, hold counter and pulse, so one port can be reset while the others keep running. The pulse output is meant to drive the synchronous clear of every register of that port.

Top module: `port_reset_detect`

## Requirements
- R1: A port's pins form a request only when rloop is 1, lloop is 1 and allones is 0. Any other combination never produces a pulse, however long it is held.
- R2: Each pin passes through a two-flop synchroniser. The synchronised request must stay asserted for at least HOLD_CYC consecutive clock cycles to qualify, where HOLD_CYC = ceil(HOLD_NS*1000/CLK_PS), with a minimum of 1. This is 20 at the default values. A request that lasts HOLD_CYC-1 cycles is ignored.
- R3: A qualified request drives port_clear for its port on the release of the request and never while it is held. Pins released just after clock edge c make the pulse appear at clock edge c+3.
- R4: Each hardware-path pulse is exactly one clock cycle wide.
- R5: If the combination is broken before it qualifies, even for one cycle, the hold count starts again from zero. Two sub-threshold pieces separated by a break do not add up.
- R6: Ports are independent. A request on one port pulses only that port's bit of port_clear, and requests released together on several ports pulse all of them in the same cycle.
- R7: A host write with host_wr_valid high, with byte bit 5 = 1, bit 6 = 1 and bit 7 = 0, and with bits 4..0 free, pulses port_clear[host_wr_port] for one cycle at the clock edge after the write is sampled.
- R8: A host write whose byte does not match the R7 bit pattern produces no pulse on any port.
- R9: While rst_n is low, port_clear is 0 and every hold counter and arming flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| pin_rloop | input | NPORTS | Remote-loopback control pin per port, asynchronous |
| pin_lloop | input | NPORTS | Local-loopback control pin per port, asynchronous |
| pin_allones | input | NPORTS | All-ones-transmit control pin per port, asynchronous |
| host_wr_valid | input | 1 | Strobe for a host control-byte write |
| host_wr_port | input | PW | Target port of the host write |
| host_wr_byte | input | 8 | Host control byte |
| port_clear | output | NPORTS | One-cycle register clear pulse per port |

## Verification
The bench holds the request for exactly HOLD_CYC and for HOLD_CYC-1 cycles. An off-by-one counter would either pulse on the short hold or miss the exact one. It breaks a held request for one cycle between two sub-threshold pieces, which catches a counter that pauses instead of restarting and so resets a port on accumulated noise. Each pulse is compared against an expected cycle measured from the release. This exposes a design that fires on the leading edge, during the hold, or with the wrong synchroniser depth. Near-miss pin and byte patterns, single-port and simultaneous two-port releases, and host writes aimed at each port expose wrong decoding, crosstalk between ports and a pulse that lasts more than one cycle.

// File: rtl/rstreq_pkg.sv
package rstreq_pkg;
  localparam int BYTE_BIT_RL = 5;
  localparam int BYTE_BIT_LL = 6;
  localparam int BYTE_BIT_AO = 7;

  // Number of sync'd cycles the request must persist (round up, at least 1).
  function automatic int hold_cycles(input int clk_ps, input int hold_ns);
    int c;
    c = (hold_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic pin_request(input logic rl, input logic ll, input logic ao);
    return rl & ll & ~ao;
  endfunction

  function automatic logic byte_request(input logic [7:0] b);
    return b[BYTE_BIT_RL] & b[BYTE_BIT_LL] & ~b[BYTE_BIT_AO];
  endfunction
endpackage

// File: rtl/rstreq_sync.sv
module rstreq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rstreq_hold.sv
module rstreq_hold #(
  parameter int HOLD_CYC = 20,
  localparam int CW      = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic armed,
  output logic fire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= armed & ~req_s;
      if (!req_s) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (!armed) begin
        if (cnt == CW'(HOLD_CYC - 1)) armed <= 1'b1;
        else                          cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstreq_host.sv
module rstreq_host #(
  parameter int NPORTS = 2,
  localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [PW-1:0]     wr_port,
  input  logic [7:0]        wr_byte,
  output logic [NPORTS-1:0] fire
);
  import rstreq_pkg::*;
  logic hit;
  assign hit = wr_valid & byte_request(wr_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) fire <= '0;
    else begin
      for (int p = 0; p < NPORTS; p++)
        fire[p] <= hit && (wr_port == PW'(p));
    end
  end
endmodule

// File: rtl/port_reset_detect.sv
module port_reset_detect #(
  parameter int NPORTS  = 2,
  parameter int CLK_PS  = 10000,
  parameter int HOLD_NS = 200,
  localparam int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] pin_rloop,
  input  logic [NPORTS-1:0] pin_lloop,
  input  logic [NPORTS-1:0] pin_allones,
  input  logic              host_wr_valid,
  input  logic [PW-1:0]     host_wr_port,
  input  logic [7:0]        host_wr_byte,
  output logic [NPORTS-1:0] port_clear
);
  import rstreq_pkg::*;
  localparam int HOLD_CYC = hold_cycles(CLK_PS, HOLD_NS);

  logic [NPORTS-1:0] rl_s, ll_s, ao_s;
  logic [NPORTS-1:0] req_s;
  logic [NPORTS-1:0] armed;
  logic [NPORTS-1:0] hw_fire;
  logic [NPORTS-1:0] host_fire;

  rstreq_sync #(.W(3*NPORTS), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pin_allones, pin_lloop, pin_rloop}),
    .q    ({ao_s, ll_s, rl_s})
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign req_s[p] = pin_request(rl_s[p], ll_s[p], ao_s[p]);

    rstreq_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .req_s(req_s[p]),
      .armed(armed[p]),
      .fire (hw_fire[p])
    );
  end

  rstreq_host #(.NPORTS(NPORTS)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(host_wr_valid),
    .wr_port (host_wr_port),
    .wr_byte (host_wr_byte),
    .fire    (host_fire)
  );

  assign port_clear = hw_fire | host_fire;
endmodule

// File: rtl/port_reset_detect_chk.sv
module port_reset_detect_chk #(
  parameter int NPORTS   = 2,
  parameter int HOLD_CYC = 20,
  parameter int PW       = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] req_s,
  input logic [NPORTS-1:0] armed,
  input logic [NPORTS-1:0] hw_fire,
  input logic [NPORTS-1:0] host_fire,
  input logic              host_wr_valid,
  input logic [PW-1:0]     host_wr_port,
  input logic [7:0]        host_wr_byte
);
  localparam int RW = $clog2(HOLD_CYC + 2);

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    logic [RW-1:0] run;
    always_ff @(posedge clk) begin
      if (!rst_n)        run <= '0;
      else if (!req_s[p]) run <= '0;
      else if (run != RW'(HOLD_CYC + 1)) run <= run + 1'b1;
    end

    // R2: arming happens exactly when HOLD_CYC unbroken request cycles are in
    assert_arm_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed[p]) |-> (run == RW'(HOLD_CYC)));

    // R5: any break drops the arming
    assert_break_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !req_s[p] |=> !armed[p]);

    // R3: a hardware pulse follows an armed request that was released
    assert_fire_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fire[p] |-> ($past(armed[p]) && !$past(req_s[p])));

    // R4: hardware pulse is one cycle wide
    assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hw_fire[p] |=> !hw_fire[p]);

    // R7: host pulse only after a matching write aimed at this port
    assert_host_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_fire[p] |-> $past(host_wr_valid && host_wr_port == PW'(p) &&
                             host_wr_byte[5] && host_wr_byte[6] && !host_wr_byte[7]));
  end

  // R6: host path pulses at most one port per cycle
  assert_host_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(host_fire));
endmodule

bind port_reset_detect port_reset_detect_chk #(
  .NPORTS(NPORTS), .HOLD_CYC(HOLD_CYC), .PW(PW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_s        (req_s),
  .armed        (armed),
  .hw_fire      (hw_fire),
  .host_fire    (host_fire),
  .host_wr_valid(host_wr_valid),
  .host_wr_port (host_wr_port),
  .host_wr_byte (host_wr_byte)
);

// File: tb/test_port_reset_detect.sv
module test_port_reset_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 2;
  localparam int HOLD = (200 * 1000 + 10000 - 1) / 10000; // 20 cycles at 10 ns

  typedef struct {
    logic [NP-1:0] mask;
    int            cyc;
    string         tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NP-1:0] rl = '0, ll = '0, ao = '0;
  logic          wv = 0;
  logic          wp = 0;
  logic [7:0]    wb = '0;
  logic [NP-1:0] port_clear;

  int   cyc = 0;
  int   n_tests = 0, n_fail = 0;
  exp_t q[$];

  port_reset_detect #(.NPORTS(NP), .CLK_PS(10000), .HOLD_NS(200)) i_port_reset_detect (
    .clk(clk), .rst_n(rst_n), .pin_rloop(rl), .pin_lloop(ll), .pin_allones(ao),
    .host_wr_valid(wv), .host_wr_port(wp), .host_wr_byte(wb), .port_clear(port_clear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // Monitor: compare each observed pulse against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && port_clear != '0) begin
      n_tests++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected pulse (R1/R2/R5/R8): actual mask=%b cyc=%0d expected none",
                 port_clear, cyc);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.mask != port_clear || e.cyc != cyc) begin
          n_fail++;
          $display("FAIL %s: actual mask=%b cyc=%0d expected mask=%b cyc=%0d",
                   e.tag, port_clear, cyc, e.mask, e.cyc);
        end
      end
    end
  end

  task automatic set_req(input int p, input logic on);
    rl[p] = on; ll[p] = on; ao[p] = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Hold a request on port p for k cycles, then release; push expected pulse.
  task automatic hw_req(input int p, input int k, input bit expect_pulse, input string tag);
    @(negedge clk);
    set_req(p, 1'b1);
    wait_n(k);
    set_req(p, 1'b0);
    if (expect_pulse) q.push_back('{mask: NP'(1) << p, cyc: cyc + 3, tag: tag});
  endtask

  task automatic host_wr(input int p, input logic [7:0] b, input bit expect_pulse, input string tag);
    @(negedge clk);
    wv = 1; wp = p[0]; wb = b;
    if (expect_pulse) q.push_back('{mask: NP'(1) << p, cyc: cyc + 1, tag: tag});
    @(negedge clk);
    wv = 0; wb = '0;
  endtask

  task automatic drain(input string tag);
    wait_n(8);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: actual missing pulses=%0d expected 0", tag, q.size());
      q.delete();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    wait_n(3);
    set_req(0, 1'b1);
    wait_n(HOLD + 3);
    n_tests++;
    if (port_clear !== '0) begin
      n_fail++;
      $display("FAIL R9: actual %b expected 00 during reset", port_clear);
    end
    set_req(0, 1'b0);
    wait_n(3);
    n_tests++;
    if (port_clear !== '0) begin
      n_fail++;
      $display("FAIL R9: actual %b expected 00 after release in reset", port_clear);
    end
    rst_n = 1;
    wait_n(4);

    // R2/R3/R4: exact hold qualifies, pulse 3 cycles after release, one wide
    hw_req(0, HOLD, 1, "R3");
    drain("R4");
    hw_req(1, HOLD + 7, 1, "R3");
    drain("R3");

    // R2: one cycle short is ignored
    hw_req(0, HOLD - 1, 0, "R2");
    drain("R2");
    hw_req(1, 2, 0, "R2");
    drain("R2");

    // R1: near-miss pin combinations never qualify
    @(negedge clk); rl[0] = 1; ll[0] = 1; ao[0] = 1; wait_n(HOLD + 5);
    rl[0] = 0; ll[0] = 0; ao[0] = 0; drain("R1");
    @(negedge clk); rl[1] = 1; ll[1] = 0; wait_n(HOLD + 5);
    rl[1] = 0; drain("R1");
    @(negedge clk); rl[0] = 0; ll[0] = 1; wait_n(HOLD + 5);
    ll[0] = 0; drain("R1");

    // R5: broken request restarts count
    @(negedge clk); set_req(0, 1);
    wait_n(HOLD - 5);
    ao[0] = 1; wait_n(1); ao[0] = 0;
    wait_n(HOLD - 5);
    set_req(0, 0);
    drain("R5");
    // R5: after a break, a full hold still qualifies
    @(negedge clk); set_req(1, 1);
    wait_n(5);
    ll[1] = 0; wait_n(1); ll[1] = 1;
    wait_n(HOLD);
    set_req(1, 0);
    q.push_back('{mask: 2'b10, cyc: cyc + 3, tag: "R5"});
    drain("R5");

    // R6: simultaneous release on both ports
    @(negedge clk); set_req(0, 1); set_req(1, 1);
    wait_n(HOLD + 2);
    set_req(0, 0); set_req(1, 0);
    q.push_back('{mask: 2'b11, cyc: cyc + 3, tag: "R6"});
    drain("R6");
    // R6: port 1 qualifies, port 0 short: only port 1
    @(negedge clk); set_req(0, 1); set_req(1, 1);
    wait_n(HOLD - 3);
    set_req(0, 0);
    wait_n(3);
    set_req(1, 0);
    q.push_back('{mask: 2'b10, cyc: cyc + 3, tag: "R6"});
    drain("R6");

    // R7: host writes (bits 4..0 free)
    host_wr(0, 8'h60, 1, "R7");
    drain("R7");
    host_wr(1, 8'h7F, 1, "R7");
    drain("R7");

    // R8: non-matching bytes
    host_wr(0, 8'hE0, 0, "R8");
    host_wr(1, 8'h20, 0, "R8");
    host_wr(0, 8'h40, 0, "R8");
    host_wr(1, 8'h1F, 0, "R8");
    drain("R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule